// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads the mapping from a two-level table that lives in memory and reaches that memory through a simple synchronous port. A single request carries the virtual address, a flag saying whether the access is a write, and a flag saying whether it comes from user mode. The walker first fetches a directory entry. If that entry describes a 4 KiB page, it then fetches a second-level entry. It checks every entry it uses for presence and access rights. When the walk succeeds, it writes the accessed flag and, for writes, the dirty flag back into memory. It then answers with either a physical address or a fault and a cause code.

Software loads a 20-bit frame number for the directory, so the directory is 4 KiB aligned. A directory entry may map a 4 MiB page directly through its size bit. In that case the second level is skipped. Only one walk is in progress at a time. The memory port gives read data on the cycle after a read is issued.

Top module: `pt_walker`

## Requirements
- R1: Bits 31..22 of the virtual address select a directory entry at `{root_base,12'h000} + 4*va[31:22]`. For a 4 KiB page, bits 21..12 select a second-level entry at `{dir_entry[31:12],12'h000} + 4*va[21:12]`.
- R2: A successful 4 KiB walk returns `{leaf_entry[31:12], va[11:0]}` with `rsp_fault` low.
- R3: When directory entry bit 7 is 1, the walk makes no second read. It returns `{dir_entry[31:22], va[21:0]}`.
- R4: If entry bit 0 (present) is 0 at either level, the walk ends with fault cause 0 (absent). This test comes before every other test.
- R5: A large-page directory entry whose bits 20..12 are not all zero gives fault cause 2 (reserved bits). This takes precedence over protection.
- R6: A write request to an entry whose bit 1 (writable) is 0 gives fault cause 1 (protection). The bit is tested at each level the walk uses.
- R7: A user-mode request to an entry whose bit 2 (user allowed) is 0 gives fault cause 1. The bit is tested at each level the walk uses.
- R8: A successful walk sets bit 5 (accessed) in the final entry. For 4 KiB pages it also sets bit 5 in the directory entry. An entry is written only if that write would change it.
- R9: Bit 6 (dirty) is set in the final entry only when a write request succeeds. A read never sets it.
- R10: A faulting walk writes nothing to memory and returns a physical address of zero.
- R11: `req_ready` is high only when the walker is idle, so only one walk is in flight. `rsp_done` is high for exactly one cycle for each accepted request.
- R12: After reset, `req_ready` is 1 and both `rsp_done` and `mem_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| root_base | input | 20 | Frame number of the directory; held stable while a walk runs |
| req_valid | input | 1 | A translation request is offered |
| req_ready | output | 1 | The walker is idle and takes the request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | The access is a write |
| req_user | input | 1 | The access is from user mode |
| rsp_done | output | 1 | One-cycle pulse: the result is valid |
| rsp_fault | output | 1 | The walk ended in a fault |
| rsp_cause | output | 2 | Fault cause: 0 absent, 1 protection, 2 reserved bits |
| rsp_paddr | output | 32 | Physical address, zero on a fault |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | The memory access is a write |
| mem_addr | output | 32 | Byte address of the table entry |
| mem_wdata | output | 32 | Updated entry for a write |
| mem_rdata | input | 32 | Read data, valid the cycle after a read |

## Verification
Translations are tried for 4 KiB and 4 MiB pages, as reads and as writes, and from user and supervisor mode. Comparing the number of reads separates the one-level path from the two-level path. Comparing the number of writes, and the entries left in memory, separates the first touch of a page from a later touch with the flags already set, and a read from a write. Each fault is set up at one level only: an absent entry at each level, a protection failure at the directory for writes and at the second level for user access, and a large page that has both reserved bits and a missing write right. These cases show that faults are ordered correctly, that each level is checked on its own, and that a faulting walk leaves memory untouched.

// File: rtl/pt_walker_pkg.sv
// Shared definitions for the page table walker.
// Assumes table entries and virtual addresses have the same width.
package pt_walker_pkg;

    localparam int B_PRESENT = 0;
    localparam int B_WRITE   = 1;
    localparam int B_USER    = 2;
    localparam int B_ACCESS  = 5;
    localparam int B_DIRTY   = 6;
    localparam int B_BIGPAGE = 7;

    typedef enum logic [1:0] {
        CZ_ABSENT = 2'd0,
        CZ_PROT   = 2'd1,
        CZ_RSVD   = 2'd2
    } cause_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR_RD,
        ST_DIR_CHK,
        ST_TBL_RD,
        ST_TBL_CHK,
        ST_WB_LEAF,
        ST_WB_DIR,
        ST_RESP
    } walk_st_e;

    typedef struct packed {
        logic   fault;
        cause_e cause;
        logic   big;
    } chk_res_t;

endpackage

// File: rtl/pt_walk_addr.sv
// Computes the byte addresses of the directory entry and the second-level entry.
// Assumes 4-byte entries and that each table is aligned to one page.
module pt_walk_addr #(
    parameter int VA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic [VA_W-OFF_W-1:0] root_frame,
    input  logic [VA_W-OFF_W-1:0] dir_frame,
    input  logic [IDX_W-1:0]      dir_idx,
    input  logic [IDX_W-1:0]      tbl_idx,
    output logic [VA_W-1:0]       dir_addr,
    output logic [VA_W-1:0]       tbl_addr
);
    localparam int PAD_W = VA_W - IDX_W - 2;

    // Add the scaled index to the base of its table.
    always_comb begin
        dir_addr = {root_frame, {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, dir_idx, 2'b00};
        tbl_addr = {dir_frame,  {OFF_W{1'b0}}} + {{PAD_W{1'b0}}, tbl_idx, 2'b00};
    end
endmodule

// File: rtl/pt_walk_check.sv
// Checks one table entry for presence, reserved bits (large pages only) and rights.
// Priority: absent, then reserved, then protection. IS_DIR enables the large-page decode.
module pt_walk_check
    import pt_walker_pkg::*;
#(
    parameter bit IS_DIR = 1'b1,
    parameter int RSV_W  = 9
) (
    input  logic             present,
    input  logic             can_write,
    input  logic             can_user,
    input  logic             big_flag,
    input  logic [RSV_W-1:0] rsv_field,
    input  logic             acc_write,
    input  logic             acc_user,
    output chk_res_t         res
);
    logic big;

    // Decide the outcome of this level.
    always_comb begin
        big       = IS_DIR && big_flag;
        res.big   = big;
        res.fault = 1'b0;
        res.cause = CZ_ABSENT;
        if (!present) begin
            res.fault = 1'b1;
            res.cause = CZ_ABSENT;
        end else if (big && (|rsv_field)) begin
            res.fault = 1'b1;
            res.cause = CZ_RSVD;
        end else if ((acc_write && !can_write) || (acc_user && !can_user)) begin
            res.fault = 1'b1;
            res.cause = CZ_PROT;
        end
    end
endmodule

// File: rtl/pt_walk_update.sv
// Builds the status-updated copy of an entry and tells whether it must be written back.
// The dirty flag is applied only when IS_LEAF is set and the access is a write.
module pt_walk_update
    import pt_walker_pkg::*;
#(
    parameter int PTE_W   = 32,
    parameter bit IS_LEAF = 1'b1
) (
    input  logic [PTE_W-1:0] ent,
    input  logic             acc_write,
    output logic [PTE_W-1:0] ent_new,
    output logic             need_wr
);
    // Set the accessed flag, and the dirty flag for a write to a leaf.
    always_comb begin
        ent_new           = ent;
        ent_new[B_ACCESS] = 1'b1;
        if (IS_LEAF && acc_write) begin
            ent_new[B_DIRTY] = 1'b1;
        end
        need_wr = (ent_new != ent);
    end
endmodule

// File: rtl/pt_walker.sv
// Two-level page table walker with 4 KiB and large pages.
// Assumes the memory returns read data one cycle after a read and that root_base
// stays stable during a walk. Only one request is in flight at a time.
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int IDX_W = 10,
    parameter int OFF_W = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [VA_W-OFF_W-1:0] root_base,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [VA_W-1:0]       req_vaddr,
    input  logic                  req_write,
    input  logic                  req_user,
    output logic                  rsp_done,
    output logic                  rsp_fault,
    output logic [1:0]            rsp_cause,
    output logic [VA_W-1:0]       rsp_paddr,
    output logic                  mem_en,
    output logic                  mem_we,
    output logic [VA_W-1:0]       mem_addr,
    output logic [VA_W-1:0]       mem_wdata,
    input  logic [VA_W-1:0]       mem_rdata
);
    localparam int PTE_W = VA_W;
    localparam int FRM_W = VA_W - OFF_W;
    localparam int BIG_W = IDX_W + OFF_W;
    localparam int RSV_W = IDX_W - 1;
    localparam int N_LVL = 2;

    walk_st_e        st;
    logic [VA_W-1:0] va_q;
    logic            wr_q;
    logic            usr_q;
    logic [PTE_W-1:0] dir_q;
    logic [PTE_W-1:0] leaf_q;
    logic [VA_W-1:0] dir_addr_q;
    logic [VA_W-1:0] leaf_addr_q;
    logic            big_q;
    logic            fault_q;
    cause_e          cause_q;
    logic [VA_W-1:0] paddr_q;

    logic [VA_W-1:0] dir_addr;
    logic [VA_W-1:0] tbl_addr;
    chk_res_t        lvl_res [N_LVL];
    logic [PTE_W-1:0] leaf_new;
    logic [PTE_W-1:0] dir_new;
    logic            leaf_need;
    logic            dir_need;

    pt_walk_addr #(
        .VA_W (VA_W),
        .IDX_W(IDX_W),
        .OFF_W(OFF_W)
    ) u_addr (
        .root_frame(root_base),
        .dir_frame (dir_q[VA_W-1:OFF_W]),
        .dir_idx   (va_q[VA_W-1 -: IDX_W]),
        .tbl_idx   (va_q[OFF_W +: IDX_W]),
        .dir_addr  (dir_addr),
        .tbl_addr  (tbl_addr)
    );

    // One checker per level; level 0 is the directory and decodes large pages.
    for (genvar g = 0; g < N_LVL; g++) begin : g_lvl
        pt_walk_check #(
            .IS_DIR(g == 0),
            .RSV_W (RSV_W)
        ) u_chk (
            .present  (mem_rdata[B_PRESENT]),
            .can_write(mem_rdata[B_WRITE]),
            .can_user (mem_rdata[B_USER]),
            .big_flag (mem_rdata[B_BIGPAGE]),
            .rsv_field(mem_rdata[OFF_W +: RSV_W]),
            .acc_write(wr_q),
            .acc_user (usr_q),
            .res      (lvl_res[g])
        );
    end

    pt_walk_update #(
        .PTE_W  (PTE_W),
        .IS_LEAF(1'b1)
    ) u_upd_leaf (
        .ent      (leaf_q),
        .acc_write(wr_q),
        .ent_new  (leaf_new),
        .need_wr  (leaf_need)
    );

    pt_walk_update #(
        .PTE_W  (PTE_W),
        .IS_LEAF(1'b0)
    ) u_upd_dir (
        .ent      (dir_q),
        .acc_write(wr_q),
        .ent_new  (dir_new),
        .need_wr  (dir_need)
    );

    // Walk sequencer: accept, read and check each level, write back, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_IDLE;
            va_q        <= '0;
            wr_q        <= 1'b0;
            usr_q       <= 1'b0;
            dir_q       <= '0;
            leaf_q      <= '0;
            dir_addr_q  <= '0;
            leaf_addr_q <= '0;
            big_q       <= 1'b0;
            fault_q     <= 1'b0;
            cause_q     <= CZ_ABSENT;
            paddr_q     <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q    <= req_vaddr;
                        wr_q    <= req_write;
                        usr_q   <= req_user;
                        fault_q <= 1'b0;
                        cause_q <= CZ_ABSENT;
                        paddr_q <= '0;
                        big_q   <= 1'b0;
                        st      <= ST_DIR_RD;
                    end
                end
                ST_DIR_RD: st <= ST_DIR_CHK;
                ST_DIR_CHK: begin
                    dir_q      <= mem_rdata;
                    dir_addr_q <= dir_addr;
                    if (lvl_res[0].fault) begin
                        fault_q <= 1'b1;
                        cause_q <= lvl_res[0].cause;
                        st      <= ST_RESP;
                    end else if (lvl_res[0].big) begin
                        big_q       <= 1'b1;
                        leaf_q      <= mem_rdata;
                        leaf_addr_q <= dir_addr;
                        paddr_q     <= {mem_rdata[VA_W-1:BIG_W], va_q[BIG_W-1:0]};
                        st          <= ST_WB_LEAF;
                    end else begin
                        st <= ST_TBL_RD;
                    end
                end
                ST_TBL_RD: st <= ST_TBL_CHK;
                ST_TBL_CHK: begin
                    if (lvl_res[1].fault) begin
                        fault_q <= 1'b1;
                        cause_q <= lvl_res[1].cause;
                        st      <= ST_RESP;
                    end else begin
                        leaf_q      <= mem_rdata;
                        leaf_addr_q <= tbl_addr;
                        paddr_q     <= {mem_rdata[VA_W-1:OFF_W], va_q[OFF_W-1:0]};
                        st          <= ST_WB_LEAF;
                    end
                end
                ST_WB_LEAF: st <= big_q ? ST_RESP : ST_WB_DIR;
                ST_WB_DIR:  st <= ST_RESP;
                ST_RESP:    st <= ST_IDLE;
                default:    st <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port from the current step of the walk.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (st)
            ST_DIR_RD: begin
                mem_en   = 1'b1;
                mem_addr = dir_addr;
            end
            ST_TBL_RD: begin
                mem_en   = 1'b1;
                mem_addr = tbl_addr;
            end
            ST_WB_LEAF: begin
                mem_en    = leaf_need;
                mem_we    = leaf_need;
                mem_addr  = leaf_addr_q;
                mem_wdata = leaf_new;
            end
            ST_WB_DIR: begin
                mem_en    = dir_need;
                mem_we    = dir_need;
                mem_addr  = dir_addr_q;
                mem_wdata = dir_new;
            end
            default: ;
        endcase
    end

    // Present the handshake and the held result.
    always_comb begin
        req_ready = (st == ST_IDLE);
        rsp_done  = (st == ST_RESP);
        rsp_fault = fault_q;
        rsp_cause = cause_q;
        rsp_paddr = fault_q ? '0 : paddr_q;
    end
endmodule

// File: rtl/pt_walker_chk.sv
// Protocol and outcome properties for pt_walker, attached by bind.
// Tracks the request offset and whether any memory write happened since acceptance.
module pt_walker_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [OFF_W-1:0] req_off,
    input logic             rsp_done,
    input logic             rsp_fault,
    input logic [1:0]       rsp_cause,
    input logic [VA_W-1:0]  rsp_paddr,
    input logic             mem_en,
    input logic             mem_we,
    input logic             wr_acc_bit
);
    logic [OFF_W-1:0] off_hold;
    logic             wrote;

    // Remember the offset and note any write during the current walk.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            off_hold <= '0;
            wrote    <= 1'b0;
        end else if (req_valid && req_ready) begin
            off_hold <= req_off;
            wrote    <= 1'b0;
        end else if (mem_en && mem_we) begin
            wrote <= 1'b1;
        end
    end

    a_r11_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r11_done_not_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);
    a_r8_write_sets_accessed: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> wr_acc_bit);
    a_r10_fault_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault) |-> (!wrote && rsp_paddr == '0));
    a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_fault) |-> (rsp_paddr[OFF_W-1:0] == off_hold));
    a_r4_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_fault) |-> (rsp_cause != 2'b11));
endmodule

bind pt_walker pt_walker_chk #(
    .VA_W (VA_W),
    .OFF_W(OFF_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_off   (req_vaddr[OFF_W-1:0]),
    .rsp_done  (rsp_done),
    .rsp_fault (rsp_fault),
    .rsp_cause (rsp_cause),
    .rsp_paddr (rsp_paddr),
    .mem_en    (mem_en),
    .mem_we    (mem_we),
    .wr_acc_bit(mem_wdata[5])
);

// File: tb/pt_walker_tb.sv
module pt_walker_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] DIR = 32'h0000_1000;
    localparam logic [31:0] T2  = 32'h0000_2000;
    localparam logic [31:0] T3  = 32'h0000_3000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [19:0] root_base;
    logic        req_valid, req_ready, req_write, req_user;
    logic [31:0] req_vaddr;
    logic        rsp_done, rsp_fault;
    logic [1:0]  rsp_cause;
    logic [31:0] rsp_paddr;
    logic        mem_en, mem_we;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:4095];
    int          n_rd = 0, n_wr = 0;
    logic        tb_we = 1'b0, tb_clr = 1'b0;
    logic [11:0] tb_idx = '0;
    logic [31:0] tb_dat = '0;
    int          checks = 0, errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_walker u_dut (
        .clk(clk), .rst_n(rst_n), .root_base(root_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_write(req_write), .req_user(req_user),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_paddr(rsp_paddr), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Memory model with one-cycle read latency plus a bench load port.
    always @(posedge clk) begin
        if (tb_clr) begin
            for (int i = 0; i < 4096; i++) mem[i] <= '0;
        end else if (tb_we) begin
            mem[tb_idx] <= tb_dat;
        end
        if (mem_en) begin
            if (mem_we) begin
                mem[mem_addr[13:2]] <= mem_wdata;
                n_wr <= n_wr + 1;
            end else begin
                mem_rdata <= mem[mem_addr[13:2]];
                n_rd <= n_rd + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] addr, input logic [31:0] val);
        @(negedge clk);
        tb_we = 1'b1; tb_idx = addr[13:2]; tb_dat = val;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    function automatic logic [31:0] peek(input logic [31:0] addr);
        return mem[addr[13:2]];
    endfunction

    function automatic logic [31:0] va(input int d, input int t, input int o);
        return {d[9:0], t[9:0], o[11:0]};
    endfunction

    task automatic walk(input logic [31:0] v, input bit w, input bit u,
                        output bit f, output logic [1:0] c, output logic [31:0] pa,
                        output int rds, output int wrs);
        int r0, w0, t;
        r0 = n_rd; w0 = n_wr;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = v; req_write = w; req_user = u;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!rsp_done && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk(t < 100, "R11 response arrives", t, 100);
        f = rsp_fault; c = rsp_cause; pa = rsp_paddr;
        rds = n_rd - r0; wrs = n_wr - w0;
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R12 ready after reset", req_ready, 1);
        chk(rsp_done == 1'b0, "R12 done low after reset", rsp_done, 0);
        chk(mem_en == 1'b0, "R12 memory idle after reset", mem_en, 0);
    endtask

    task automatic t_small_page();
        bit f; logic [1:0] c; logic [31:0] pa; int r, w;
        poke(DIR + 4*3, 32'h0000_2007);
        poke(T2 + 4*5, 32'h1234_5007);
        walk(va(3, 5, 12'hABC), 1'b0, 1'b1, f, c, pa, r, w);
        chk(!f && pa == 32'h1234_5ABC, "R2 small page address", pa, 32'h1234_5ABC);
        chk(r == 2, "R1 two-level reads", r, 2);
        chk(peek(T2 + 4*5) == 32'h1234_5027, "R8 leaf accessed", peek(T2 + 4*5), 32'h1234_5027);
        chk(peek(DIR + 4*3) == 32'h0000_2027, "R8 dir accessed", peek(DIR + 4*3), 32'h0000_2027);
        chk(w == 2, "R9 read leaves dirty clear, two writes", w, 2);
        walk(va(3, 5, 12'h010), 1'b0, 1'b1, f, c, pa, r, w);
        chk(w == 0, "R8 no rewrite when flags set", w, 0);
        walk(va(3, 5, 12'h020), 1'b1, 1'b1, f, c, pa, r, w);
        chk(!f && w == 1, "R9 write sets dirty, one write", w, 1);
        chk(peek(T2 + 4*5) == 32'h1234_5067, "R9 leaf dirty", peek(T2 + 4*5), 32'h1234_5067);
    endtask

    task automatic t_large_page();
        bit f; logic [1:0] c; logic [31:0] pa; int r, w;
        poke(DIR + 4*7, 32'hABC0_0087);
        walk({10'd7, 22'h2F_1234}, 1'b1, 1'b1, f, c, pa, r, w);
        chk(!f && pa == 32'hABEF_1234, "R3 large page address", pa, 32'hABEF_1234);
        chk(r == 1, "R3 single read", r, 1);
        chk(peek(DIR + 4*7) == 32'hABC0_00E7, "R9 large entry flags", peek(DIR + 4*7), 32'hABC0_00E7);
    endtask

    task automatic t_handshake();
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va(3, 5, 0); req_write = 1'b0; req_user = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R11 busy after accept", req_ready, 0);
        while (!rsp_done) @(negedge clk);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R11 done one cycle", rsp_done, 0);
        chk(req_ready == 1'b1, "R11 idle after response", req_ready, 1);
    endtask

    task automatic t_absent();
        bit f; logic [1:0] c; logic [31:0] pa; int r, w;
        walk(va(9, 0, 0), 1'b0, 1'b0, f, c, pa, r, w);
        chk(f && c == 2'd0, "R4 absent directory", {f, c}, 3'b100);
        chk(pa == 0 && w == 0, "R10 fault quiet", pa, 0);
        poke(DIR + 4*10, 32'h0000_3007);
        poke(T3 + 4*2, 32'h5555_5006);
        walk(va(10, 2, 0), 1'b1, 1'b1, f, c, pa, r, w);
        chk(f && c == 2'd0, "R4 absent leaf over rights", {f, c}, 3'b100);
        chk(w == 0 && peek(DIR + 4*10) == 32'h0000_3007, "R10 dir untouched", peek(DIR + 4*10), 32'h0000_3007);
    endtask

    task automatic t_reserved();
        bit f; logic [1:0] c; logic [31:0] pa; int r, w;
        poke(DIR + 4*11, 32'hC000_1085);
        walk(va(11, 0, 0), 1'b1, 1'b0, f, c, pa, r, w);
        chk(f && c == 2'd2, "R5 reserved bits over protection", {f, c}, 3'b110);
    endtask

    task automatic t_protection();
        bit f; logic [1:0] c; logic [31:0] pa; int r, w;
        poke(DIR + 4*12, 32'h0000_3005);
        poke(T3 + 4*4, 32'h6666_6007);
        walk(va(12, 4, 12'h044), 1'b1, 1'b0, f, c, pa, r, w);
        chk(f && c == 2'd1, "R6 write blocked at directory", {f, c}, 3'b101);
        chk(w == 0 && peek(T3 + 4*4) == 32'h6666_6007, "R10 leaf untouched", peek(T3 + 4*4), 32'h6666_6007);
        walk(va(12, 4, 12'h044), 1'b0, 1'b0, f, c, pa, r, w);
        chk(!f && pa == 32'h6666_6044, "R6 read allowed", pa, 32'h6666_6044);
        poke(DIR + 4*13, 32'h0000_3007);
        poke(T3 + 4*6, 32'h7777_7003);
        walk(va(13, 6, 12'h300), 1'b0, 1'b1, f, c, pa, r, w);
        chk(f && c == 2'd1, "R7 user blocked at leaf", {f, c}, 3'b101);
        walk(va(13, 6, 12'h300), 1'b0, 1'b0, f, c, pa, r, w);
        chk(!f && pa == 32'h7777_7300, "R7 supervisor allowed", pa, 32'h7777_7300);
        poke(DIR + 4*14, 32'h4000_0083);
        walk(va(14, 0, 0), 1'b0, 1'b1, f, c, pa, r, w);
        chk(f && c == 2'd1, "R7 user blocked on large page", {f, c}, 3'b101);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; root_base = DIR[31:12];
        req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0; req_user = 1'b0;
        tb_clr = 1'b1;
        repeat (3) @(negedge clk);
        tb_clr = 1'b0;
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_small_page();
        t_large_page();
        t_handshake();
        t_absent();
        t_reserved();
        t_protection();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule